// File: doc/BRIEF.md
# Bridge Master Abort Responder

This block decides how a bus-to-bus bridge reacts when a transaction it forwarded as master ends in master abort on the far interface. The abort can occur on either side of the bridge. For each abort event it looks at four things: the transaction direction, whether a posted write has already completed toward the original requester, a stored abort-reporting mode bit, and the system-error enable from the primary command register. It then picks a single response.

With reporting off, the bridge hides the abort. Reads get all-ones data and write data is dropped. With reporting on, a transaction that is still open toward the requester is ended with a target abort. A posted write that has already completed cannot be aborted any more. It is reported through a system-error pulse when that report is enabled, and otherwise it is dropped without a report. The bus state machines that carry out these responses sit outside this block. They consume its one-cycle pulses.

Top module: `bridge_mabort_resp`

## Requirements
- R1: After reset the reporting mode bit reads 0, and every response output (`ones_rtn`, `tgt_abort`, `sys_err`, `wr_discard`, `resp_side`, `rd_data`) is 0.
- R2: When reporting is off, an abort on a read gives `ones_rtn`=1 one clock after the event. In that same cycle `rd_data` is all ones. In every other cycle `rd_data` is 0.
- R3: When reporting is off, an abort on a write gives `wr_discard`=1 one clock after the event. In that cycle `tgt_abort` and `sys_err` stay 0.
- R4: When reporting is on, an abort on an outstanding transaction gives `tgt_abort`=1 one clock after the event, with `wr_discard`=0. An outstanding transaction is any read, or a write with `posted_done`=0.
- R5: When reporting is on, an abort on a write with `posted_done`=1 and `cmd_serr_en`=1 gives both `sys_err`=1 and `wr_discard`=1 one clock after the event.
- R6: When reporting is on, an abort on a write with `posted_done`=1 and `cmd_serr_en`=0 gives only `wr_discard`=1. No report is raised.
- R7: For each abort event, at most one of `ones_rtn`, `tgt_abort` and `sys_err` pulses. Each output is high for exactly one cycle. A cycle with no abort event produces no output one clock later.
- R8: A write to the mode bit takes effect on the next cycle. An abort presented in the same cycle as the mode write is decided with the old mode. `mode_bit` shows the stored value.
- R9: `resp_side` repeats the event's `abort_side` value (0 = primary, 1 = secondary) in the response cycle. The decision rules are the same for both sides.
- R10: For a read, `posted_done` has no effect: when reporting is on, a read with `posted_done`=1 still gets a target abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load strobe for the reporting mode bit |
| mode_wdata | input | 1 | New value for the reporting mode bit |
| cmd_serr_en | input | 1 | System-error enable from the primary command register |
| abort_evt | input | 1 | One-cycle master-abort event on a forwarded transaction |
| abort_side | input | 1 | Interface on which the abort occurred (0 primary, 1 secondary) |
| is_write | input | 1 | 1 for a write, 0 for a read |
| posted_done | input | 1 | The posted write has already completed toward the requester |
| mode_bit | output | 1 | Stored reporting mode bit |
| ones_rtn | output | 1 | Pulse: complete the read with all-ones data |
| rd_data | output | DATA_W | All-ones read data during `ones_rtn`, otherwise 0 |
| tgt_abort | output | 1 | Pulse: signal target abort to the requester |
| sys_err | output | 1 | Pulse: assert system error |
| wr_discard | output | 1 | Pulse: drop the write data |
| resp_side | output | 1 | Side of the abort being answered, valid with the pulses |

## Verification
Every response output comes from a single register stage, so it is due exactly one clock after the abort event, and it must be back at 0 one further clock later. A mode write becomes visible on `mode_bit` one clock after its strobe. The bench drives each stimulus on a falling edge and samples on the next falling edge, which lands in the response cycle. It then samples once more to confirm that the pulse has ended. For the same-cycle case, the mode write and the abort share one falling edge, and the response cycle is checked against the old mode while `mode_bit` is checked against the new one.

// File: rtl/bridge_mabort_resp.sv
module bridge_mabort_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              mode_wdata,
  input  logic              cmd_serr_en,
  input  logic              abort_evt,
  input  logic              abort_side,
  input  logic              is_write,
  input  logic              posted_done,
  output logic              mode_bit,
  output logic              ones_rtn,
  output logic [DATA_W-1:0] rd_data,
  output logic              tgt_abort,
  output logic              sys_err,
  output logic              wr_discard,
  output logic              resp_side
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic mode_q;
  logic outstanding;
  logic nx_ones, nx_tabort, nx_serr, nx_disc;

  assign outstanding = !is_write || !posted_done;

  assign nx_ones   = abort_evt && !mode_q && !is_write;
  assign nx_tabort = abort_evt &&  mode_q && outstanding;
  assign nx_serr   = abort_evt &&  mode_q && !outstanding && cmd_serr_en;
  assign nx_disc   = abort_evt &&  is_write && (!mode_q || !outstanding);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      ones_rtn   <= 1'b0;
      tgt_abort  <= 1'b0;
      sys_err    <= 1'b0;
      wr_discard <= 1'b0;
      resp_side  <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      ones_rtn   <= nx_ones;
      tgt_abort  <= nx_tabort;
      sys_err    <= nx_serr;
      wr_discard <= nx_disc;
      resp_side  <= abort_evt && abort_side;
    end
  end

  assign mode_bit = mode_q;
  assign rd_data  = ones_rtn ? ALL_ONES : '0;

endmodule

// File: rtl/bridge_mabort_resp_chk.sv
module bridge_mabort_resp_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic              mode_wdata,
  input logic              cmd_serr_en,
  input logic              abort_evt,
  input logic              abort_side,
  input logic              is_write,
  input logic              posted_done,
  input logic              mode_bit,
  input logic              ones_rtn,
  input logic [DATA_W-1:0] rd_data,
  input logic              tgt_abort,
  input logic              sys_err,
  input logic              wr_discard,
  input logic              resp_side
);

  p_one_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ones_rtn, tgt_abort, sys_err}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_evt |=> !(ones_rtn || tgt_abort || sys_err || wr_discard || resp_side));

  p_rdata_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ones_rtn |-> (rd_data == {DATA_W{1'b1}}));

  p_rdata_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ones_rtn |-> (rd_data == '0));

  p_quiet_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !is_write && !mode_bit) |=> ones_rtn);

  p_quiet_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && is_write && !mode_bit) |=> (wr_discard && !tgt_abort && !sys_err));

  p_tabort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && mode_bit && (!is_write || !posted_done)) |=> (tgt_abort && !wr_discard));

  p_serr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && mode_bit && is_write && posted_done && cmd_serr_en) |=> (sys_err && wr_discard));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && mode_bit && is_write && posted_done && !cmd_serr_en) |=> (wr_discard && !sys_err && !tgt_abort));

  p_mode_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_bit == $past(mode_wdata)));

  p_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (resp_side == $past(abort_side)));

endmodule

bind bridge_mabort_resp bridge_mabort_resp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
  .cmd_serr_en(cmd_serr_en), .abort_evt(abort_evt), .abort_side(abort_side),
  .is_write(is_write), .posted_done(posted_done), .mode_bit(mode_bit),
  .ones_rtn(ones_rtn), .rd_data(rd_data), .tgt_abort(tgt_abort),
  .sys_err(sys_err), .wr_discard(wr_discard), .resp_side(resp_side)
);

// File: tb/bridge_mabort_resp_tb.sv
module bridge_mabort_resp_tb;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0, mode_wdata = 1'b0, cmd_serr_en = 1'b0;
  logic abort_evt = 1'b0, abort_side = 1'b0, is_write = 1'b0, posted_done = 1'b0;
  logic mode_bit, ones_rtn, tgt_abort, sys_err, wr_discard, resp_side;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_mabort_resp #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cmd_serr_en(cmd_serr_en), .abort_evt(abort_evt), .abort_side(abort_side),
    .is_write(is_write), .posted_done(posted_done), .mode_bit(mode_bit),
    .ones_rtn(ones_rtn), .rd_data(rd_data), .tgt_abort(tgt_abort),
    .sys_err(sys_err), .wr_discard(wr_discard), .resp_side(resp_side)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {ones_rtn, tgt_abort, sys_err, wr_discard, resp_side};
  endfunction

  task automatic set_mode(input logic v);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
    chk("R8 mode load", {63'd0, mode_bit}, {63'd0, v});
  endtask

  // one abort; expected {ones,tabort,serr,discard,side} one clock later, then all zero
  task automatic abort_case(input string req, input logic wr, input logic pd,
                            input logic se, input logic side, input logic [4:0] exp);
    @(negedge clk);
    abort_evt = 1'b1; is_write = wr; posted_done = pd;
    cmd_serr_en = se; abort_side = side;
    @(negedge clk);
    abort_evt = 1'b0;
    chk(req, {59'd0, outs()}, {59'd0, exp});
    chk({req, " rd_data"}, {32'd0, rd_data}, exp[4] ? {32'd0, {DW{1'b1}}} : 64'd0);
    @(negedge clk);
    chk({"R7 pulse end ", req}, {59'd0, outs()}, 64'd0);
    chk("R2 rd_data idle", {32'd0, rd_data}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 mode", {63'd0, mode_bit}, 64'd0);
    chk("R1 outs", {59'd0, outs()}, 64'd0);
    chk("R1 rd_data", {32'd0, rd_data}, 64'd0);
  endtask

  task automatic t_quiet_mode();
    abort_case("R2 read", 1'b0, 1'b0, 1'b1, 1'b0, 5'b10000);
    abort_case("R9 R2 read secondary", 1'b0, 1'b1, 1'b0, 1'b1, 5'b10001);
    abort_case("R3 write", 1'b1, 1'b0, 1'b1, 1'b0, 5'b00010);
    abort_case("R3 posted write", 1'b1, 1'b1, 1'b1, 1'b1, 5'b00011);
  endtask

  task automatic t_report_mode();
    abort_case("R4 read", 1'b0, 1'b0, 1'b1, 1'b0, 5'b01000);
    abort_case("R4 write outstanding", 1'b1, 1'b0, 1'b1, 1'b1, 5'b01001);
    abort_case("R10 read posted_done", 1'b0, 1'b1, 1'b1, 1'b0, 5'b01000);
    abort_case("R5 serr", 1'b1, 1'b1, 1'b1, 1'b0, 5'b00110);
    abort_case("R9 R5 serr secondary", 1'b1, 1'b1, 1'b1, 1'b1, 5'b00111);
    abort_case("R6 silent drop", 1'b1, 1'b1, 1'b0, 1'b0, 5'b00010);
  endtask

  task automatic t_idle();
    @(negedge clk);
    is_write = 1'b1; posted_done = 1'b1; cmd_serr_en = 1'b1; abort_side = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 no event", {59'd0, outs()}, 64'd0);
    end
  endtask

  task automatic t_same_cycle();
    // mode currently 1; clear it in the same cycle as a read abort
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = 1'b0;
    abort_evt = 1'b1; is_write = 1'b0; posted_done = 1'b0; abort_side = 1'b0;
    @(negedge clk);
    mode_we = 1'b0; abort_evt = 1'b0;
    chk("R8 old mode used", {59'd0, outs()}, {59'd0, 5'b01000});
    chk("R8 new mode stored", {63'd0, mode_bit}, 64'd0);
    abort_case("R8 new mode used", 1'b0, 1'b0, 1'b0, 1'b0, 5'b10000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_quiet_mode();
    t_idle();
    set_mode(1'b1);
    t_report_mode();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule